// File: doc/BRIEF.md
# Programmable Interrupt Priority Resolver

This block picks one interrupt source to service out of a set of pending requests and presents its source number and its 16-bit vector address. The sources form two groups. Six non-maskable sources (three reset causes, an external high-priority request, an unimplemented-opcode trap and a software interrupt) sit in a fixed order that cannot be changed. Twenty-seven maskable sources follow a fixed default order. A small priority-select register can move any one maskable source to the head of the maskable group. Vector fetch and register stacking belong to the processor and are not part of this block.

The first maskable source is an external active-low request line. It can be sensed on its level or on a falling edge, and a captured edge is held until the processor acknowledges the grant. The global X bit gates the external high-priority request and the I bit gates the whole maskable group. Alongside each grant the block reports which of these mask bits the processor must set when it takes the interrupt. The priority-select register takes a write only while the I bit is set, so the order never changes while a maskable interrupt is being arbitrated.

The grant is combinational from the request inputs and the internal state. The only state is the priority-select register and the edge latch of the external line.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset the priority-select register holds 7'h6F, which elevates maskable source 10 (vector FFDE). With nothing pending, gnt_valid is 0.
- R2: Source codes 0, 1 and 2 are power/pin reset, clock-monitor reset and watchdog reset, with vectors FFFE, FFFC and FFFA. The lowest pending code among them wins over every other source. These grants set both X and I.
- R3: Code 3 is the external high-priority request, with vector FFF4. It is granted only while x_mask is 0, and then it sets both X and I. When x_mask is 1 it is ignored.
- R4: Maskable source k (0..26) has code 6+k and vector FF00 + (F2 − 2k). Maskable sources are ignored while i_mask is 1. Otherwise the lowest pending k wins, unless the elevated source is pending. A maskable grant sets I only.
- R5: A register value p elevates maskable source k = 7'h79 − p, provided 0 ≤ k ≤ 26. When it is pending, that source wins over all other maskable sources.
- R6: A write to the priority-select register (psel_data = vector low byte bits 7:1) takes effect in the next cycle, and only when i_mask is 1 during the write. Otherwise the write is ignored.
- R7: A register value that maps to no maskable source leaves the default maskable order in force.
- R8: With irq_edge_en = 0, maskable source 0 is pending in the same cycle that irq_n is low.
- R9: With irq_edge_en = 1, a falling edge of irq_n is captured and source 0 becomes pending from the next cycle. The capture holds until ack is high while source 0 is granted. A line that stays low does not request again.
- R10: The trap (code 4, vector FFF8) and the software interrupt (code 5, vector FFF6) lose to any enabled pending source, maskable ones included. The trap wins over the software interrupt. Both set I only.
- R11: Reset causes, the trap and the software interrupt are granted whatever the state of i_mask. Reset causes are also granted whatever the state of x_mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_req | input | 6 | Non-maskable requests, bit n is source code n |
| per_req | input | 26 | Maskable requests for sources 1..26 (bit j is source j+1) |
| irq_n | input | 1 | External maskable request line, active low |
| irq_edge_en | input | 1 | 1: falling-edge sensing, 0: low-level sensing |
| x_mask | input | 1 | X mask bit |
| i_mask | input | 1 | I mask bit |
| psel_wr | input | 1 | Priority-select write strobe |
| psel_data | input | 7 | Bits 7:1 of the vector low byte to elevate |
| ack | input | 1 | Grant taken by the processor |
| gnt_valid | output | 1 | A source is granted |
| gnt_idx | output | 6 | Granted source code |
| gnt_vec | output | 16 | Vector address of the granted source |
| gnt_set_x | output | 1 | Taking this grant sets X |
| gnt_set_i | output | 1 | Taking this grant sets I |

## Verification
Level requests, mask bits and the elevated choice reach the grant outputs in the same cycle, so the bench drives inputs on the falling clock edge and compares 1 ns later, before the next rising edge. A write to the register, a captured falling edge of irq_n and an acknowledge each act only through a rising edge. The bench keeps its own copies of the register and the edge latch, and updates them on that edge. Their effect is therefore checked in the half cycle after that edge, and the directed steps check the cycle of the stimulus itself for the value still unchanged.

// File: rtl/irqres_pkg.sv
package irqres_pkg;
    localparam int NMI_N     = 6;
    localparam int MASK_N    = 27;
    localparam int SRC_N     = NMI_N + MASK_N;
    localparam int IDX_W     = $clog2(SRC_N);
    localparam int MIDX_W    = $clog2(MASK_N);
    localparam int PSEL_W    = 7;
    localparam logic [7:0] MASK_TOP_LO = 8'hF2;
    localparam logic [PSEL_W-1:0] PSEL_TOP = MASK_TOP_LO[7:1];
    localparam logic [PSEL_W-1:0] PSEL_RST = 7'h6F;
    localparam logic [7:0] VEC_PAGE = 8'hFF;

    typedef enum logic [2:0] {
        SRC_PWR   = 3'd0,
        SRC_CLKMON = 3'd1,
        SRC_WDOG  = 3'd2,
        SRC_XREQ  = 3'd3,
        SRC_TRAP  = 3'd4,
        SRC_SWI   = 3'd5
    } nmi_src_e;

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  idx;
        logic [15:0]       vec;
        logic              set_x;
        logic              set_i;
    } grant_t;

    function automatic logic [7:0] nmi_vec_lo(input nmi_src_e s);
        case (s)
            SRC_PWR:    return 8'hFE;
            SRC_CLKMON: return 8'hFC;
            SRC_WDOG:   return 8'hFA;
            SRC_XREQ:   return 8'hF4;
            SRC_TRAP:   return 8'hF8;
            default:    return 8'hF6;
        endcase
    endfunction

    function automatic logic [7:0] mask_vec_lo(input logic [MIDX_W-1:0] k);
        return MASK_TOP_LO - {2'b00, k, 1'b0};
    endfunction
endpackage

// File: rtl/irqres_sense.sv
module irqres_sense (
    input  logic clk,
    input  logic rst,
    input  logic irq_n,
    input  logic edge_en,
    input  logic clr,
    output logic active
);
    logic prev_q;
    logic latch_q;
    logic fall;

    assign fall = prev_q & ~irq_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b1;
            latch_q <= 1'b0;
        end else begin
            prev_q  <= irq_n;
            latch_q <= edge_en & (fall | (latch_q & ~clr));
        end
    end

    assign active = edge_en ? latch_q : ~irq_n;

    // R9: a falling edge seen in edge mode is pending in the next cycle
    p_edge_capture_r9: assert property (@(posedge clk) disable iff (rst)
        (edge_en && $fell(irq_n)) |=> (active || !edge_en));
endmodule

// File: rtl/irqres_psel.sv
module irqres_psel #(
    parameter int N  = irqres_pkg::MASK_N,
    parameter int PW = irqres_pkg::PSEL_W,
    parameter int EW = irqres_pkg::MIDX_W,
    parameter logic [PW-1:0] TOP = irqres_pkg::PSEL_TOP,
    parameter logic [PW-1:0] RST = irqres_pkg::PSEL_RST
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [PW-1:0] wdata,
    input  logic          i_mask,
    output logic          elev_valid,
    output logic [EW-1:0] elev_idx
);
    logic [PW-1:0] psel_q;
    logic [PW-1:0] diff;

    always_ff @(posedge clk) begin
        if (rst)
            psel_q <= RST;
        else if (wr && i_mask)
            psel_q <= wdata;
    end

    assign diff       = TOP - psel_q;
    assign elev_valid = (psel_q <= TOP) && (diff < PW'(N));
    assign elev_idx   = diff[EW-1:0];

    // R6: the register only changes through a write made with I set
    p_psel_locked_r6: assert property (@(posedge clk) disable iff (rst)
        (!wr || !i_mask) |=> $stable(psel_q));
    // R6: a write with I set lands in the next cycle
    p_psel_write_r6: assert property (@(posedge clk) disable iff (rst)
        (wr && i_mask) |=> (psel_q == $past(wdata)));
endmodule

// File: rtl/irqres_mask_arb.sv
module irqres_mask_arb #(
    parameter int N  = irqres_pkg::MASK_N,
    parameter int EW = irqres_pkg::MIDX_W
) (
    input  logic [N-1:0]  req,
    input  logic          elev_valid,
    input  logic [EW-1:0] elev_idx,
    output logic          any,
    output logic [EW-1:0] win
);
    always_comb begin
        any = |req;
        win = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) win = EW'(k);
        end
        if (elev_valid && req[elev_idx]) win = elev_idx;
    end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
    import irqres_pkg::*;
#(
    parameter int NUM_MASK = MASK_N
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NMI_N-1:0]     nmi_req,
    input  logic [NUM_MASK-2:0]  per_req,
    input  logic                 irq_n,
    input  logic                 irq_edge_en,
    input  logic                 x_mask,
    input  logic                 i_mask,
    input  logic                 psel_wr,
    input  logic [PSEL_W-1:0]    psel_data,
    input  logic                 ack,
    output logic                 gnt_valid,
    output logic [IDX_W-1:0]     gnt_idx,
    output logic [15:0]          gnt_vec,
    output logic                 gnt_set_x,
    output logic                 gnt_set_i
);
    localparam int RST_N = 3;
    localparam logic [IDX_W-1:0] MASK_BASE = IDX_W'(NMI_N);

    logic                irq_active;
    logic                irq_clr;
    logic                elev_valid;
    logic [MIDX_W-1:0]   elev_idx;
    logic [NUM_MASK-1:0] mreq;
    logic                m_any;
    logic [MIDX_W-1:0]   m_win;
    grant_t              g;

    irqres_sense u_sense (
        .clk(clk), .rst(rst), .irq_n(irq_n), .edge_en(irq_edge_en),
        .clr(irq_clr), .active(irq_active)
    );

    irqres_psel #(.N(NUM_MASK)) u_psel (
        .clk(clk), .rst(rst), .wr(psel_wr), .wdata(psel_data),
        .i_mask(i_mask), .elev_valid(elev_valid), .elev_idx(elev_idx)
    );

    assign mreq = {per_req, irq_active} & {NUM_MASK{~i_mask}};

    irqres_mask_arb #(.N(NUM_MASK)) u_arb (
        .req(mreq), .elev_valid(elev_valid), .elev_idx(elev_idx),
        .any(m_any), .win(m_win)
    );

    always_comb begin
        g = '0;
        if (|nmi_req[RST_N-1:0]) begin
            for (int r = RST_N - 1; r >= 0; r--) begin
                if (nmi_req[r]) begin
                    g.idx = IDX_W'(r);
                    g.vec = {VEC_PAGE, nmi_vec_lo(nmi_src_e'(r))};
                end
            end
            g.valid = 1'b1;
            g.set_x = 1'b1;
            g.set_i = 1'b1;
        end else if (nmi_req[SRC_XREQ] && !x_mask) begin
            g.valid = 1'b1;
            g.idx   = IDX_W'(SRC_XREQ);
            g.vec   = {VEC_PAGE, nmi_vec_lo(SRC_XREQ)};
            g.set_x = 1'b1;
            g.set_i = 1'b1;
        end else if (m_any) begin
            g.valid = 1'b1;
            g.idx   = MASK_BASE + IDX_W'(m_win);
            g.vec   = {VEC_PAGE, mask_vec_lo(m_win)};
            g.set_i = 1'b1;
        end else if (nmi_req[SRC_TRAP]) begin
            g.valid = 1'b1;
            g.idx   = IDX_W'(SRC_TRAP);
            g.vec   = {VEC_PAGE, nmi_vec_lo(SRC_TRAP)};
            g.set_i = 1'b1;
        end else if (nmi_req[SRC_SWI]) begin
            g.valid = 1'b1;
            g.idx   = IDX_W'(SRC_SWI);
            g.vec   = {VEC_PAGE, nmi_vec_lo(SRC_SWI)};
            g.set_i = 1'b1;
        end
    end

    assign irq_clr   = ack && g.valid && (g.idx == MASK_BASE);
    assign gnt_valid = g.valid;
    assign gnt_idx   = g.idx;
    assign gnt_vec   = g.vec;
    assign gnt_set_x = g.set_x;
    assign gnt_set_i = g.set_i;

    // R2: power/pin reset beats every other source
    p_pwr_first_r2: assert property (@(posedge clk) disable iff (rst)
        nmi_req[SRC_PWR] |-> (gnt_valid && gnt_idx == IDX_W'(SRC_PWR)));
    // R3: the external high-priority request is never granted under X
    p_xmask_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        x_mask |-> !(gnt_valid && gnt_idx == IDX_W'(SRC_XREQ)));
    // R4: no maskable grant under I
    p_imask_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        i_mask |-> !(gnt_valid && gnt_idx >= MASK_BASE));
    // R4: a maskable grant never sets X and always sets I
    p_mask_sets_i_r4: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && gnt_idx >= MASK_BASE) |-> (gnt_set_i && !gnt_set_x));
    // R11: a pending reset cause is always granted whatever the masks
    p_rst_unmasked_r11: assert property (@(posedge clk) disable iff (rst)
        (|nmi_req[RST_N-1:0]) |-> (gnt_valid && gnt_idx < IDX_W'(RST_N)));
    // R10: the software interrupt only wins when nothing else is pending
    p_swi_last_r10: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && gnt_idx == IDX_W'(SRC_SWI)) |-> (nmi_req[SRC_TRAP:0] == '0 || nmi_req[SRC_TRAP:0] == 5'b01000));
endmodule

// File: tb/sim_irq_prio_resolver.sv
module sim_irq_prio_resolver;
    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  nmi_req;
    logic [25:0] per_req;
    logic        irq_n, irq_edge_en, x_mask, i_mask, psel_wr, ack;
    logic [6:0]  psel_data;
    logic        gnt_valid, gnt_set_x, gnt_set_i;
    logic [5:0]  gnt_idx;
    logic [15:0] gnt_vec;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    logic [6:0] m_psel;
    logic       m_latch, m_prev;

    always #2 clk = ~clk;

    irq_prio_resolver u0 (
        .clk(clk), .rst(rst), .nmi_req(nmi_req), .per_req(per_req),
        .irq_n(irq_n), .irq_edge_en(irq_edge_en), .x_mask(x_mask),
        .i_mask(i_mask), .psel_wr(psel_wr), .psel_data(psel_data), .ack(ack),
        .gnt_valid(gnt_valid), .gnt_idx(gnt_idx), .gnt_vec(gnt_vec),
        .gnt_set_x(gnt_set_x), .gnt_set_i(gnt_set_i)
    );

    function automatic int exp_idx(input logic [5:0] n, input logic [25:0] p,
                                   input logic irqact, input logic x, input logic i,
                                   input logic [6:0] ps);
        logic [26:0] m;
        int e;
        for (int r = 0; r < 3; r++) if (n[r]) return r;
        if (n[3] && !x) return 3;
        if (!i) begin
            m = {p, irqact};
            e = 121 - int'(ps);
            if (e >= 0 && e <= 26 && m[e]) return 6 + e;
            for (int k = 0; k < 27; k++) if (m[k]) return 6 + k;
        end
        if (n[4]) return 4;
        if (n[5]) return 5;
        return -1;
    endfunction

    function automatic logic [15:0] vec_of(input int idx);
        case (idx)
            0: return 16'hFFFE;
            1: return 16'hFFFC;
            2: return 16'hFFFA;
            3: return 16'hFFF4;
            4: return 16'hFFF8;
            5: return 16'hFFF6;
            default: return 16'hFFF2 - 16'(2 * (idx - 6));
        endcase
    endfunction

    function automatic int model_idx();
        logic act;
        act = irq_edge_en ? m_latch : ~irq_n;
        return exp_idx(nmi_req, per_req, act, x_mask, i_mask, m_psel);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_psel  <= 7'h6F;
            m_latch <= 1'b0;
            m_prev  <= 1'b1;
        end else begin
            if (psel_wr && i_mask) m_psel <= psel_data;
            m_prev  <= irq_n;
            m_latch <= irq_edge_en & ((m_prev & ~irq_n) | (m_latch & ~(ack && model_idx() == 6)));
        end
    end

    task automatic chk_idx(input string tag, input int e);
        int got;
        logic bad;
        got = gnt_valid ? int'(gnt_idx) : -1;
        bad = (got != e);
        if (e >= 0) begin
            if (gnt_vec != vec_of(e)) bad = 1'b1;
            if (gnt_set_x != (e <= 3)) bad = 1'b1;
            if (!gnt_set_i) bad = 1'b1;
        end
        tests++;
        if (bad) begin
            fails++;
            $display("FAIL %s: idx=%0d vec=%h x=%b i=%b expected idx=%0d vec=%h",
                     tag, got, gnt_vec, gnt_set_x, gnt_set_i, e, (e >= 0) ? vec_of(e) : 16'h0);
        end
    endtask

    task automatic idle();
        nmi_req = '0; per_req = '0; irq_n = 1'b1; irq_edge_en = 1'b0;
        x_mask = 1'b0; i_mask = 1'b0; psel_wr = 1'b0; psel_data = '0; ack = 1'b0;
    endtask

    task automatic at_neg();
        @(negedge clk);
        idle();
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        $display("FAIL watchdog: run did not end, expected finish before %0d cycles", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1 chk_idx("R1 idle", -1);

        at_neg(); per_req[9] = 1'b1; irq_n = 1'b0;
        #1 chk_idx("R1 default elevation", 16);

        at_neg(); nmi_req = 6'b000110;
        #1 chk_idx("R2 clkmon over wdog", 1);
        at_neg(); nmi_req = 6'b111111; x_mask = 1'b1; i_mask = 1'b1;
        #1 chk_idx("R2 R11 pwr first under masks", 0);

        at_neg(); nmi_req = 6'b001000; per_req[0] = 1'b1;
        #1 chk_idx("R3 xreq open", 3);
        at_neg(); nmi_req = 6'b001000; per_req[0] = 1'b1; x_mask = 1'b1;
        #1 chk_idx("R3 xreq masked", 7);

        at_neg(); per_req[0] = 1'b1; per_req[5] = 1'b1; i_mask = 1'b1;
        #1 chk_idx("R4 I blocks", -1);
        at_neg(); per_req[0] = 1'b1; per_req[5] = 1'b1;
        #1 chk_idx("R4 default order", 7);

        at_neg(); psel_wr = 1'b1; psel_data = 7'h5F;
        at_neg(); per_req[0] = 1'b1; per_req[25] = 1'b1;
        #1 chk_idx("R6 write ignored without I", 7);

        at_neg(); psel_wr = 1'b1; psel_data = 7'h5F; i_mask = 1'b1; per_req[0] = 1'b1; per_req[25] = 1'b1;
        #1 chk_idx("R6 write not yet visible", 4 - 5);
        at_neg(); per_req[0] = 1'b1; per_req[25] = 1'b1;
        #1 chk_idx("R5 source 26 elevated", 32);

        at_neg(); psel_wr = 1'b1; psel_data = 7'h00; i_mask = 1'b1;
        at_neg(); per_req[3] = 1'b1; per_req[25] = 1'b1;
        #1 chk_idx("R7 no match default order", 10);

        at_neg(); irq_n = 1'b0; per_req[2] = 1'b1;
        #1 chk_idx("R8 level low", 6);

        at_neg(); irq_edge_en = 1'b1;
        at_neg(); irq_edge_en = 1'b1; irq_n = 1'b0; per_req[2] = 1'b1;
        #1 chk_idx("R9 edge not yet captured", 9);
        at_neg(); irq_edge_en = 1'b1; irq_n = 1'b0; per_req[2] = 1'b1;
        #1 chk_idx("R9 edge captured", 6);
        at_neg(); irq_edge_en = 1'b1; irq_n = 1'b0; ack = 1'b1;
        #1 chk_idx("R9 held until ack", 6);
        at_neg(); irq_edge_en = 1'b1; irq_n = 1'b0;
        #1 chk_idx("R9 cleared, low line no re-request", -1);

        at_neg(); nmi_req = 6'b010000; per_req[12] = 1'b1;
        #1 chk_idx("R10 maskable over trap", 19);
        at_neg(); nmi_req = 6'b110000; per_req[12] = 1'b1; i_mask = 1'b1;
        #1 chk_idx("R10 R11 trap under I", 4);
        at_neg(); nmi_req = 6'b100000; i_mask = 1'b1; x_mask = 1'b1;
        #1 chk_idx("R10 swi alone", 5);

        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            for (int b = 0; b < 6; b++) nmi_req[b] = ($urandom % 24 == 0);
            for (int b = 0; b < 26; b++) per_req[b] = ($urandom % 18 == 0);
            if ($urandom % 4 == 0) irq_n = ~irq_n;
            if ($urandom % 40 == 0) irq_edge_en = ~irq_edge_en;
            x_mask = ($urandom % 3 == 0);
            i_mask = ($urandom % 3 == 0);
            psel_wr = ($urandom % 6 == 0);
            psel_data = ($urandom % 2 == 0) ? 7'(7'h5F + $urandom % 27) : 7'($urandom);
            ack = ($urandom % 2 == 0);
            #1 chk_idx("R5 random mix", model_idx());
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule